// File: doc/BRIEF.md
# Inbound DMA Cache-Line Request Splitter

This block sits between an I/O port and a coherent home agent. It takes one inbound DMA request at a time. Each request gives a byte address, a byte length, a read or write direction and an allocation hint. The block cuts the request into coherent messages, each no larger than one 64-byte cache line. Every message carries a line-aligned address and a byte-enable mask that marks the bytes of the line the request covers.

A read becomes one read-current message per line. The whole line is fetched even when only part of it is wanted. A write line is handled in two phases. First the block sends an ownership message, whose opcode depends on whether the piece is full or partial. It then waits for an ownership grant and takes one beat of line data from the write-data channel. Last, it sends a data message. That closing message is a writeback for allocating requests and a flush for non-allocating ones. Lines go out in ascending address order. The final message of a request is marked, and a one-cycle done pulse follows its acceptance.

Top module: `dma_line_splitter`

## Requirements
- R1: After reset cq_valid and done are 0, and req_ready is 1.
- R2: A request is cut on 64-byte boundaries. Its lines are issued in ascending address order, and cq_addr is always the line base (low 6 bits zero).
- R3: Bit i of cq_be is 1 exactly when byte i of the addressed line lies inside [req_addr, req_addr+req_len).
- R4: A read issues exactly one message per line, with opcode 1 (read current), and no ownership or data message.
- R5: Each write line first issues an ownership message. The opcode is 2 when the piece covers all 64 bytes and 3 when it covers fewer.
- R6: A write line's data message is issued only after a grant_valid pulse that arrives after its ownership message was accepted. A grant that arrives at any other time is ignored. The data message carries the wd_data beat taken for that line.
- R7: For an allocating write the data message has opcode 4 (writeback). For a non-allocating write (req_noalloc=1) it has opcode 5 (flush).
- R8: cq_last is 1 only on the final message of a request. done pulses for one cycle, in the cycle after that message is accepted.
- R9: While cq_valid is 1 and cq_ready is 0, the message (valid, opcode, address, byte enables, data) is held unchanged.
- R10: A zero-length request is accepted, produces no message, and is followed by a done pulse in the next cycle.
- R11: req_ready is 0 while a request is in progress, so a second request is not taken until the first is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Inbound request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_noalloc | input | 1 | Non-allocating hint for writes |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| wd_valid | input | 1 | Line data beat present |
| wd_ready | output | 1 | Block taking a line data beat |
| wd_data | input | 8*LINE_BYTES | Line data, byte i in bits [8i+7:8i] |
| grant_valid | input | 1 | Ownership grant pulse from the home agent |
| cq_valid | output | 1 | Coherent message valid |
| cq_ready | input | 1 | Home agent accepts the message |
| cq_op | output | 3 | Opcode: 1 read, 2 own full, 3 own partial, 4 writeback, 5 flush |
| cq_addr | output | ADDR_W | Line-aligned address |
| cq_be | output | LINE_BYTES | Byte enables within the line |
| cq_data | output | 8*LINE_BYTES | Line data for writeback or flush, zero otherwise |
| cq_last | output | 1 | Final message of the request |
| done | output | 1 | One-cycle pulse after the request completes |

## Verification
The assertions check the following on every cycle. Messages stay line-aligned and carry a non-empty byte mask. The full-ownership opcode appears only with an all-ones mask and the partial one only without it. A stalled message does not change. No writeback or flush is raised while an ownership grant is still owed. An accepted last message is always followed by done. The directed scenarios show the rest: the order and number of lines for aligned, unaligned and single-byte requests, the exact byte masks, the choice of closing opcode, and the data carried. They also show that an early grant is ignored, that zero-length requests behave as required, and that the block reports busy while a request is in progress.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_RDCUR    = 3'd1,
    OP_OWN_FULL = 3'd2,
    OP_OWN_PART = 3'd3,
    OP_WB       = 3'd4,
    OP_FLUSH    = 3'd5
  } cq_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SEND_OWN, S_GRANT, S_WDATA, S_SEND_FIN
  } seq_state_e;
endpackage

// File: rtl/dls_be_gen.sv
module dls_be_gen #(
  parameter int LINE_BYTES = 64,
  localparam int OFFW = $clog2(LINE_BYTES)
) (
  input  logic [OFFW-1:0]       off,
  input  logic [OFFW:0]         piece,
  output logic [LINE_BYTES-1:0] be
);
  logic [OFFW:0] end_pos;
  assign end_pos = {1'b0, off} + piece;

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    assign be[i] = ((OFFW+1)'(i) >= {1'b0, off}) && ((OFFW+1)'(i) < end_pos);
  end
endmodule

// File: rtl/dls_slicer.sv
module dls_slicer #(
  parameter int LEN_W      = 13,
  parameter int LINE_BYTES = 64,
  localparam int OFFW = $clog2(LINE_BYTES)
) (
  input  logic [OFFW-1:0]       off,
  input  logic [LEN_W-1:0]      rem,
  output logic [OFFW:0]         piece,
  output logic                  full,
  output logic [LINE_BYTES-1:0] be
);
  logic [OFFW:0] room;
  assign room  = (OFFW+1)'(LINE_BYTES) - {1'b0, off};
  assign piece = (rem < LEN_W'(room)) ? rem[OFFW:0] : room;
  assign full  = (piece == (OFFW+1)'(LINE_BYTES));

  dls_be_gen #(.LINE_BYTES(LINE_BYTES)) u_be (
    .off  (off),
    .piece(piece),
    .be   (be)
  );
endmodule

// File: rtl/dls_seq.sv
module dls_seq
  import dls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 13,
  parameter int LINE_BYTES = 64,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int DW   = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_noalloc,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  output logic [OFFW-1:0]       sl_off,
  output logic [LEN_W-1:0]      sl_rem,
  input  logic [OFFW:0]         sl_piece,
  input  logic                  sl_full,
  input  logic [LINE_BYTES-1:0] sl_be,
  input  logic                  grant_valid,
  input  logic                  wd_valid,
  output logic                  wd_ready,
  input  logic [DW-1:0]         wd_data,
  output logic                  cq_valid,
  input  logic                  cq_ready,
  output logic [2:0]            cq_op,
  output logic [ADDR_W-1:0]     cq_addr,
  output logic [LINE_BYTES-1:0] cq_be,
  output logic [DW-1:0]         cq_data,
  output logic                  cq_last,
  output logic                  done
);
  seq_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem;
  logic              is_wr, noalloc, last_r;
  logic [OFFW:0]     piece_r;
  cq_op_e            op_q;

  assign sl_off    = cur_addr[OFFW-1:0];
  assign sl_rem    = rem;
  assign req_ready = (state == S_IDLE);
  assign wd_ready  = (state == S_WDATA);
  assign cq_op     = op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      is_wr    <= 1'b0;
      noalloc  <= 1'b0;
      last_r   <= 1'b0;
      piece_r  <= '0;
      cq_valid <= 1'b0;
      op_q     <= OP_NONE;
      cq_addr  <= '0;
      cq_be    <= '0;
      cq_data  <= '0;
      cq_last  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            rem      <= req_len;
            is_wr    <= req_write;
            noalloc  <= req_noalloc;
            if (req_len == '0) done  <= 1'b1;
            else               state <= S_LOAD;
          end
        end
        S_LOAD: begin
          piece_r  <= sl_piece;
          last_r   <= (rem == LEN_W'(sl_piece));
          cq_addr  <= {cur_addr[ADDR_W-1:OFFW], {OFFW{1'b0}}};
          cq_be    <= sl_be;
          cq_data  <= '0;
          cq_valid <= 1'b1;
          if (is_wr) begin
            op_q    <= sl_full ? OP_OWN_FULL : OP_OWN_PART;
            cq_last <= 1'b0;
            state   <= S_SEND_OWN;
          end else begin
            op_q    <= OP_RDCUR;
            cq_last <= (rem == LEN_W'(sl_piece));
            state   <= S_SEND_FIN;
          end
        end
        S_SEND_OWN: begin
          if (cq_ready) begin
            cq_valid <= 1'b0;
            state    <= S_GRANT;
          end
        end
        S_GRANT: begin
          if (grant_valid) state <= S_WDATA;
        end
        S_WDATA: begin
          if (wd_valid) begin
            op_q     <= noalloc ? OP_FLUSH : OP_WB;
            cq_data  <= wd_data;
            cq_last  <= last_r;
            cq_valid <= 1'b1;
            state    <= S_SEND_FIN;
          end
        end
        S_SEND_FIN: begin
          if (cq_ready) begin
            cq_valid <= 1'b0;
            cur_addr <= {cur_addr[ADDR_W-1:OFFW] + 1'b1, {OFFW{1'b0}}};
            rem      <= rem - LEN_W'(piece_r);
            if (last_r) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_LOAD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Grant tracker: an ownership message accepted but not yet granted.
  logic own_pend;
  always_ff @(posedge clk) begin
    if (rst) own_pend <= 1'b0;
    else if (cq_valid && cq_ready && (op_q == OP_OWN_FULL || op_q == OP_OWN_PART))
      own_pend <= 1'b1;
    else if (grant_valid)
      own_pend <= 1'b0;
  end

  // R6: no data message while a grant is still owed
  a_r6_grant_first: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && (op_q == OP_WB || op_q == OP_FLUSH)) |-> !own_pend);

  // R9: stalled message held
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && !cq_ready) |=> (cq_valid && $stable(cq_op) && $stable(cq_addr)
                                 && $stable(cq_be) && $stable(cq_data)));

  // R2: line-aligned addresses
  a_r2_line_aligned: assert property (@(posedge clk) disable iff (rst)
    cq_valid |-> (cq_addr[OFFW-1:0] == '0));

  // R3: every message covers at least one byte
  a_r3_be_nonempty: assert property (@(posedge clk) disable iff (rst)
    cq_valid |-> (|cq_be));

  // R5: ownership opcode matches full/partial coverage
  a_r5_own_full: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && op_q == OP_OWN_FULL) |-> (&cq_be));
  a_r5_own_part: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && op_q == OP_OWN_PART) |-> !(&cq_be));

  // R8: accepted last message followed by done
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && cq_ready && cq_last) |=> done);
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 13,
  parameter int LINE_BYTES = 64,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int DW   = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_noalloc,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  wd_valid,
  output logic                  wd_ready,
  input  logic [DW-1:0]         wd_data,
  input  logic                  grant_valid,
  output logic                  cq_valid,
  input  logic                  cq_ready,
  output logic [2:0]            cq_op,
  output logic [ADDR_W-1:0]     cq_addr,
  output logic [LINE_BYTES-1:0] cq_be,
  output logic [DW-1:0]         cq_data,
  output logic                  cq_last,
  output logic                  done
);
  logic [OFFW-1:0]       sl_off;
  logic [LEN_W-1:0]      sl_rem;
  logic [OFFW:0]         sl_piece;
  logic                  sl_full;
  logic [LINE_BYTES-1:0] sl_be;

  dls_slicer #(.LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_slicer (
    .off  (sl_off),
    .rem  (sl_rem),
    .piece(sl_piece),
    .full (sl_full),
    .be   (sl_be)
  );

  dls_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_noalloc(req_noalloc),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .sl_off     (sl_off),
    .sl_rem     (sl_rem),
    .sl_piece   (sl_piece),
    .sl_full    (sl_full),
    .sl_be      (sl_be),
    .grant_valid(grant_valid),
    .wd_valid   (wd_valid),
    .wd_ready   (wd_ready),
    .wd_data    (wd_data),
    .cq_valid   (cq_valid),
    .cq_ready   (cq_ready),
    .cq_op      (cq_op),
    .cq_addr    (cq_addr),
    .cq_be      (cq_be),
    .cq_data    (cq_data),
    .cq_last    (cq_last),
    .done       (done)
  );
endmodule

// File: tb/tb_dma_line_splitter.sv
`timescale 1ns/1ps
module tb_dma_line_splitter;
  localparam int AW = 32, LW = 13, LB = 64, DW = 512;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_noalloc = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic req_ready, wd_ready;
  logic wd_valid = 1;
  logic [DW-1:0] wd_data = 0;
  logic grant_valid = 0;
  logic cq_valid, cq_last, done;
  logic cq_ready = 1;
  logic [2:0] cq_op;
  logic [AW-1:0] cq_addr;
  logic [LB-1:0] cq_be;
  logic [DW-1:0] cq_data;

  always #2.5 clk = ~clk;

  dma_line_splitter #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB)) dut (.*);

  int checks = 0, errors = 0;
  int cyc = 0, last_cyc = -10, done_cnt = 0;
  int ready_mode = 0, gdelay = 0;
  bit auto_grant = 1, man_grant = 0, zero_mode = 0, prev_stall = 0;
  logic [2:0] p_op; logic [AW-1:0] p_addr; logic [LB-1:0] p_be; logic [DW-1:0] p_data;

  logic [2:0]    rec_op   [0:63];
  logic [AW-1:0] rec_addr [0:63];
  logic [LB-1:0] rec_be   [0:63];
  logic [DW-1:0] rec_data [0:63];
  logic          rec_last [0:63];
  int n_rec = 0;

  function automatic logic [DW-1:0] data_for(logic [AW-1:0] a);
    return {16{a ^ 32'h5A5A_0000}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (prev_stall)
      chk(cq_valid && cq_op == p_op && cq_addr == p_addr && cq_be == p_be && cq_data == p_data,
          "R9", "stalled message changed", {cq_addr, 29'd0, cq_op}, {p_addr, 29'd0, p_op});
    grant_valid = 0;
    if (man_grant) begin grant_valid = 1; man_grant = 0; end
    if (gdelay > 0) begin gdelay--; if (gdelay == 0) grant_valid = 1; end
    case (ready_mode)
      0: cq_ready = 1;
      1: cq_ready = cyc[0];
      default: cq_ready = 0;
    endcase
    if (cq_valid && cq_ready && n_rec < 64) begin
      rec_op[n_rec] = cq_op; rec_addr[n_rec] = cq_addr; rec_be[n_rec] = cq_be;
      rec_data[n_rec] = cq_data; rec_last[n_rec] = cq_last; n_rec++;
      if (cq_op == 3'd2 || cq_op == 3'd3) begin
        wd_data = data_for(cq_addr);
        if (auto_grant) gdelay = 3;
      end
      if (cq_last) last_cyc = cyc;
    end
    if (done) begin
      done_cnt++;
      if (!zero_mode) chk(cyc == last_cyc + 1, "R8", "done timing", 64'(cyc), 64'(last_cyc + 1));
    end
    prev_stall = cq_valid && !cq_ready;
    p_op = cq_op; p_addr = cq_addr; p_be = cq_be; p_data = cq_data;
  end

  task automatic send(bit wr, bit na, logic [AW-1:0] a, logic [LW-1:0] l);
    int t = 0;
    @(negedge clk);
    while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    n_rec = 0;
    req_write = wr; req_noalloc = na; req_addr = a; req_len = l; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(int start);
    int t = 0;
    while (done_cnt == start && t < 2000) begin @(negedge clk); t++; end
    chk(done_cnt != start, "R8", "done seen", 64'(done_cnt), 64'(start + 1));
    repeat (2) @(negedge clk);
  endtask

  // Expected message list from R2-R8, compared with recorded messages
  task automatic expect_msgs(string tag, bit wr, bit na, logic [AW-1:0] a0, int len);
    logic [AW-1:0] a = a0, line;
    int r = len, k = 0;
    while (r > 0) begin
      int off = int'(a[5:0]);
      int p = (r < 64 - off) ? r : 64 - off;
      logic [LB-1:0] be = '0;
      bit lst = (r == p);
      for (int i = 0; i < 64; i++) be[i] = (i >= off) && (i < off + p);
      line = {a[AW-1:6], 6'd0};
      if (!wr) begin
        chk(k < n_rec && rec_op[k] == 3'd1 && rec_addr[k] == line && rec_be[k] == be && rec_last[k] == lst,
            tag, "read line", k < n_rec ? rec_be[k] : 64'd0, be);
        k++;
      end else begin
        chk(k < n_rec && rec_op[k] == (p == 64 ? 3'd2 : 3'd3) && rec_addr[k] == line && rec_be[k] == be
            && !rec_last[k], tag, "own msg", k < n_rec ? 64'(rec_op[k]) : 64'd0, p == 64 ? 64'd2 : 64'd3);
        k++;
        chk(k < n_rec && rec_op[k] == (na ? 3'd5 : 3'd4) && rec_addr[k] == line && rec_be[k] == be
            && rec_last[k] == lst && rec_data[k] == data_for(line), tag, "data msg",
            k < n_rec ? 64'(rec_op[k]) : 64'd0, na ? 64'd5 : 64'd4);
        k++;
      end
      a = line + 64; r -= p;
    end
    chk(n_rec == k, tag, "message count", 64'(n_rec), 64'(k));
  endtask

  task automatic run(string tag, bit wr, bit na, logic [AW-1:0] a, int len);
    int s = done_cnt;
    send(wr, na, a, LW'(len));
    wait_done(s);
    expect_msgs(tag, wr, na, a, len);
  endtask

  task automatic t_reset;
    chk(!cq_valid && !done && req_ready, "R1", "reset state",
        {61'd0, cq_valid, done, req_ready}, 64'd1);
  endtask

  task automatic t_read_aligned;   run("R4", 0, 0, 32'h1000, 64); endtask
  task automatic t_read_span;      run("R2", 0, 0, 32'h2030, 100); endtask
  task automatic t_write_full;     run("R5", 1, 0, 32'h3000, 128); endtask
  task automatic t_write_partial;  run("R3", 1, 0, 32'h4005, 70); endtask
  task automatic t_noalloc;        run("R7", 1, 1, 32'h5000, 72); endtask
  task automatic t_single_byte;    run("R3", 0, 0, 32'h703F, 1); endtask

  task automatic t_backpressure;
    int s = done_cnt;
    ready_mode = 1;
    send(0, 0, 32'h6010, 200);
    repeat (2) @(negedge clk);
    chk(!req_ready, "R11", "busy req_ready", 64'(req_ready), 64'd0);
    wait_done(s);
    expect_msgs("R9", 0, 0, 32'h6010, 200);
    s = done_cnt;
    send(1, 1, 32'h6100, 130);
    wait_done(s);
    expect_msgs("R9", 1, 1, 32'h6100, 130);
    ready_mode = 0;
  endtask

  task automatic t_grant_order;
    int s = done_cnt;
    auto_grant = 0;
    ready_mode = 2;
    man_grant = 1;                 // grant while idle: ignored
    send(1, 0, 32'h8000, 64);
    repeat (3) @(negedge clk);
    man_grant = 1;                 // grant before ownership accepted: ignored
    repeat (3) @(negedge clk);
    ready_mode = 0;
    repeat (12) @(negedge clk);
    chk(n_rec == 1, "R6", "no data before grant", 64'(n_rec), 64'd1);
    chk(wd_ready == 0, "R6", "no wd take before grant", 64'(wd_ready), 64'd0);
    man_grant = 1;
    wait_done(s);
    expect_msgs("R6", 1, 0, 32'h8000, 64);
    auto_grant = 1;
  endtask

  task automatic t_zero_len;
    int s = done_cnt;
    zero_mode = 1;
    send(1, 0, 32'h9000, 0);
    wait_done(s);
    chk(n_rec == 0, "R10", "zero length messages", 64'(n_rec), 64'd0);
    zero_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_aligned();
    t_read_span();
    t_write_full();
    t_write_partial();
    t_noalloc();
    t_single_byte();
    t_backpressure();
    t_grant_order();
    t_zero_len();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule